// File: doc/BRIEF.md
# Single-Wire Frame Master Sequencer

This block runs whole read and write frames for a master on a pulse-width coded single-wire bus. A host loads a direction flag, a slave address, a register address and, for writes, a data byte, then pulses `start`. The sequencer turns the frame into a stream of symbol requests for a separate bit codec: a run of synchronisation pulses, the header bits, a header parity bit, then either the outgoing data byte and its parity or listen slots in which the slave drives the bus. The last slot is always the slave's acknowledge.

The codec is reached through a symbol handshake. The sequencer presents `sym_kind` with `sym_valid`. The codec completes the symbol by raising `sym_done` for one cycle. In a listen slot it also returns the sampled bus value on `sym_rx_bit`. Pulse timing and the bus driver live in the codec. When the frame ends, the sequencer pulses `done` and reports the received byte, a data parity mismatch and a negative acknowledge.

Top module: `swf_frame_master`

## Requirements
- R1: After reset, `busy`, `done`, `sym_valid`, `parity_err`, `ack_err` and `rd_data` are all 0.
- R2: A `start` seen while idle latches `dir_in`, `slave_addr`, `reg_addr` and `wr_data`, raises `busy` in the next cycle, and opens the frame with PAUSE_SYNCS (default 3) symbols of kind SYNC (code 0).
- R3: After the pause, the header is sent in this order: the direction bit, then `slave_addr`, then `reg_addr`, each field most significant bit first. A 0 bit uses kind ZERO (code 1) and a 1 bit uses kind ONE (code 2).
- R4: The header parity symbol follows the header. It is ONE when the 8 header bits hold an odd number of ones, and ZERO otherwise.
- R5: When `reg_addr` bit 3 is 1 (write), the next symbols are the 8 data bits, most significant bit first, then a data parity bit that is ONE exactly when the byte holds an odd number of ones, then one LISTEN symbol (code 3) for the acknowledge.
- R6: When `reg_addr` bit 3 is 0 (read), the header parity is followed by 10 LISTEN symbols. These carry the data bits (most significant first), then the data parity bit, then the acknowledge.
- R7: A presented symbol keeps `sym_valid` high and `sym_kind` unchanged until a cycle with `sym_done` high. The next symbol is presented in the following cycle.
- R8: In the cycle after the acknowledge symbol completes, `done` is high for exactly one cycle, `busy` is low, and `ack_err` equals the acknowledge value that was sampled.
- R9: At the end of a read, `rd_data` holds the received byte, and `parity_err` is 1 exactly when the received parity bit differs from the odd-parity of that byte. At the end of a write, `parity_err` is 0 and `rd_data` keeps its previous value.
- R10: A `start` that arrives while `busy` is high is ignored, and the frame in progress continues with its latched fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (accepted only while idle) |
| dir_in | input | 1 | Direction bit to send |
| slave_addr | input | 3 | Slave address |
| reg_addr | input | 4 | Register address; bit 3 = 1 selects write |
| wr_data | input | 8 | Byte to send on a write |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 8 | Byte received on the last read |
| parity_err | output | 1 | Received data parity mismatch on the last frame |
| ack_err | output | 1 | Slave returned acknowledge 1 on the last frame |
| sym_valid | output | 1 | A symbol request is presented to the codec |
| sym_kind | output | 2 | 0 SYNC, 1 ZERO, 2 ONE, 3 LISTEN |
| sym_done | input | 1 | Codec finished the presented symbol |
| sym_rx_bit | input | 1 | Bus value sampled by the codec in a listen slot |

## Verification
The bench runs random frames with random fields, bus bits and codec delays. It adds directed cases: an all-zero read header, a write of 0xFF, 0x00 and odd-weight bytes, a read with deliberately wrong parity, and a negative acknowledge. Comparing the symbol stream position by position separates field order and bit order faults from parity faults. Reads and writes with the same register field differ only in bit 3, so they show whether ownership of the data slots switches correctly. Junk on `sym_rx_bit` during slots the master drives, together with a `start` pulse in mid-frame, shows that neither stimulus alters the frame or its results.

// File: rtl/swf_pkg.sv
package swf_pkg;

  typedef enum logic [1:0] {
    SYM_SYNC   = 2'd0,
    SYM_ZERO   = 2'd1,
    SYM_ONE    = 2'd2,
    SYM_LISTEN = 2'd3
  } sym_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PAUSE,
    PH_HDR,
    PH_P1,
    PH_DATA,
    PH_P2,
    PH_ACK
  } phase_e;

  // odd-parity indicator: 1 when v holds an odd number of ones
  function automatic logic odd_ones(input logic [31:0] v);
    return ^v;
  endfunction

  function automatic sym_e bit_sym(input logic b);
    return b ? SYM_ONE : SYM_ZERO;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/swf_phase_ctrl.sv
module swf_phase_ctrl
  import swf_pkg::*;
#(
  parameter int PAUSE_SYNCS = 3,
  parameter int HDR_W       = 8,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             sym_fire,
  output phase_e           phase,
  output logic [CNT_W-1:0] bit_idx,
  output logic             phase_last,
  output logic             frame_end
);

  logic [CNT_W-1:0] last_idx;

  always_comb begin
    case (phase)
      PH_PAUSE: last_idx = CNT_W'(PAUSE_SYNCS - 1);
      PH_HDR:   last_idx = CNT_W'(HDR_W - 1);
      PH_DATA:  last_idx = CNT_W'(DATA_W - 1);
      default:  last_idx = '0;
    endcase
  end

  assign phase_last = (bit_idx == last_idx);
  assign frame_end  = sym_fire && (phase == PH_ACK);

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_PAUSE: return PH_HDR;
      PH_HDR:   return PH_P1;
      PH_P1:    return PH_DATA;
      PH_DATA:  return PH_P2;
      PH_P2:    return PH_ACK;
      default:  return PH_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
    end else if (phase == PH_IDLE) begin
      bit_idx <= '0;
      if (launch) phase <= PH_PAUSE;
    end else if (sym_fire) begin
      if (phase_last) begin
        bit_idx <= '0;
        phase   <= next_phase(phase);
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swf_tx_select.sv
module swf_tx_select
  import swf_pkg::*;
#(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  phase_e            phase,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [HDR_W-1:0]  hdr_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic              is_write,
  output sym_e              kind
);

  logic [HDR_W-1:0]  hdr_sh;
  logic [DATA_W-1:0] data_sh;
  logic              hdr_par;
  logic              data_par;

  assign hdr_sh   = hdr_q << bit_idx;
  assign data_sh  = data_q << bit_idx;
  assign hdr_par  = odd_ones(32'(hdr_q));
  assign data_par = odd_ones(32'(data_q));

  always_comb begin
    case (phase)
      PH_HDR:  kind = bit_sym(hdr_sh[HDR_W-1]);
      PH_P1:   kind = bit_sym(hdr_par);
      PH_DATA: kind = is_write ? bit_sym(data_sh[DATA_W-1]) : SYM_LISTEN;
      PH_P2:   kind = is_write ? bit_sym(data_par) : SYM_LISTEN;
      PH_ACK:  kind = SYM_LISTEN;
      default: kind = SYM_SYNC;
    endcase
  end

endmodule

// File: rtl/swf_rx_collect.sv
module swf_rx_collect
  import swf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              sym_fire,
  input  logic              rx_bit,
  input  logic              is_write,
  input  logic              frame_end,
  output logic [DATA_W-1:0] rd_data,
  output logic              parity_err,
  output logic              ack_err,
  output logic              done
);

  logic [DATA_W-1:0] rx_shift;
  logic              rx_par;
  logic              take_data;
  logic              take_par;

  assign take_data = sym_fire && !is_write && (phase == PH_DATA);
  assign take_par  = sym_fire && !is_write && (phase == PH_P2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_shift   <= '0;
      rx_par     <= 1'b0;
      rd_data    <= '0;
      parity_err <= 1'b0;
      ack_err    <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= frame_end;
      if (take_data) rx_shift <= {rx_shift[DATA_W-2:0], rx_bit};
      if (take_par)  rx_par   <= rx_bit;
      if (frame_end) begin
        ack_err <= rx_bit;
        if (is_write) begin
          parity_err <= 1'b0;
        end else begin
          rd_data    <= rx_shift;
          parity_err <= odd_ones(32'(rx_shift)) ^ rx_par;
        end
      end
    end
  end

endmodule

// File: rtl/swf_frame_master.sv
module swf_frame_master
  import swf_pkg::*;
#(
  parameter int PAUSE_SYNCS = 3,
  parameter int SA_W        = 3,
  parameter int RA_W        = 4,
  parameter int DATA_W      = 8,
  parameter int WRITE_BIT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_in,
  input  logic [SA_W-1:0]   slave_addr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              parity_err,
  output logic              ack_err,
  output logic              sym_valid,
  output logic [1:0]        sym_kind,
  input  logic              sym_done,
  input  logic              sym_rx_bit
);

  localparam int HDR_W  = 1 + SA_W + RA_W;
  localparam int MAXLEN = max3(PAUSE_SYNCS, HDR_W, DATA_W);
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_e            phase;
  logic [CNT_W-1:0]  bit_idx;
  logic              phase_last;
  logic              frame_end;
  logic              launch;
  logic              sym_fire;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] data_q;
  logic              is_write;
  sym_e              kind;

  assign busy      = (phase != PH_IDLE);
  assign sym_valid = busy;
  assign launch    = start && !busy;
  assign sym_fire  = sym_valid && sym_done;
  assign sym_kind  = kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q    <= '0;
      data_q   <= '0;
      is_write <= 1'b0;
    end else if (launch) begin
      hdr_q    <= {dir_in, slave_addr, reg_addr};
      data_q   <= wr_data;
      is_write <= reg_addr[WRITE_BIT];
    end
  end

  swf_phase_ctrl #(
    .PAUSE_SYNCS(PAUSE_SYNCS), .HDR_W(HDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .launch(launch), .sym_fire(sym_fire),
    .phase(phase), .bit_idx(bit_idx), .phase_last(phase_last),
    .frame_end(frame_end)
  );

  swf_tx_select #(
    .HDR_W(HDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_tx (
    .phase(phase), .bit_idx(bit_idx), .hdr_q(hdr_q), .data_q(data_q),
    .is_write(is_write), .kind(kind)
  );

  swf_rx_collect #(
    .DATA_W(DATA_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .phase(phase), .sym_fire(sym_fire),
    .rx_bit(sym_rx_bit), .is_write(is_write), .frame_end(frame_end),
    .rd_data(rd_data), .parity_err(parity_err), .ack_err(ack_err),
    .done(done)
  );

endmodule

// File: rtl/swf_frame_master_chk.sv
module swf_frame_master_chk
  import swf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       sym_valid,
  input logic       sym_done,
  input logic [1:0] sym_kind,
  input logic       parity_err,
  input phase_e     phase,
  input logic       is_write,
  input logic       frame_end
);

  a_r2_pause_is_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> (sym_kind == 2'd0));

  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r6_read_listens: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !is_write && (phase == PH_DATA || phase == PH_P2)) |-> (sym_kind == 2'd3));

  a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_done) |=> (sym_valid && $stable(sym_kind)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(frame_end) && !busy));

  a_r9_write_no_perr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_write) |-> !parity_err);

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> busy);

endmodule

bind swf_frame_master swf_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sym_valid(sym_valid), .sym_done(sym_done), .sym_kind(sym_kind),
  .parity_err(parity_err), .phase(phase), .is_write(is_write),
  .frame_end(frame_end)
);

// File: tb/swf_frame_master_test.sv
`timescale 1ns/1ps
module swf_frame_master_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       dir_in = 1'b0;
  logic [2:0] slave_addr = '0;
  logic [3:0] reg_addr = '0;
  logic [7:0] wr_data = '0;
  logic       busy, done, parity_err, ack_err, sym_valid;
  logic [7:0] rd_data;
  logic [1:0] sym_kind;
  logic       sym_done = 1'b0;
  logic       sym_rx_bit = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model_rd = 8'h00;
  bit finished = 0;

  always #4 clk = ~clk;

  swf_frame_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in),
    .slave_addr(slave_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .parity_err(parity_err),
    .ack_err(ack_err), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .sym_done(sym_done), .sym_rx_bit(sym_rx_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] v);
    return ($countones(v) % 2) == 1;
  endfunction

  function automatic int code_of(input logic b);
    return b ? 2 : 1;
  endfunction

  task automatic run_frame(input logic d, input logic [2:0] sa, input logic [3:0] ra,
                           input logic [7:0] wd, input logic [7:0] rxd,
                           input logic rxp2, input logic rxack, input bit poke);
    int exp_k [0:31];
    logic rx_b [0:31];
    string tag [0:31];
    int n = 0;
    logic [7:0] hdr;
    bit wr;
    hdr = {d, sa, ra};
    wr = ra[3];
    for (int i = 0; i < 3; i++) begin exp_k[n] = 0; rx_b[n] = 1'($urandom); tag[n] = "R2"; n++; end
    for (int i = 7; i >= 0; i--) begin exp_k[n] = code_of(hdr[i]); rx_b[n] = 1'($urandom); tag[n] = "R3"; n++; end
    exp_k[n] = code_of(par_of(hdr)); rx_b[n] = 1'($urandom); tag[n] = "R4"; n++;
    for (int i = 7; i >= 0; i--) begin
      exp_k[n] = wr ? code_of(wd[i]) : 3;
      rx_b[n] = wr ? 1'($urandom) : rxd[i];
      tag[n] = wr ? "R5" : "R6"; n++;
    end
    exp_k[n] = wr ? code_of(par_of(wd)) : 3; rx_b[n] = wr ? 1'($urandom) : rxp2;
    tag[n] = wr ? "R5" : "R6"; n++;
    exp_k[n] = 3; rx_b[n] = rxack; tag[n] = wr ? "R5" : "R6"; n++;

    @(negedge clk);
    dir_in = d; slave_addr = sa; reg_addr = ra; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dir_in = ~d; slave_addr = ~sa; reg_addr = ~ra; wr_data = ~wd;
    check(busy == 1'b1, "R2", int'(busy), 1);
    for (int s = 0; s < n; s++) begin
      int waits = $urandom_range(0, 2);
      if (poke && s == 6) begin
        // R10: a start pulse in mid-frame must not restart the frame
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", int'(busy), 1);
      end
      for (int w = 0; w < waits; w++) begin
        check(sym_valid && int'(sym_kind) == exp_k[s], "R7", int'(sym_kind), exp_k[s]);
        @(negedge clk);
      end
      check(sym_valid == 1'b1, "R7", int'(sym_valid), 1);
      check(int'(sym_kind) == exp_k[s], poke ? {tag[s], "/R10"} : tag[s], int'(sym_kind), exp_k[s]);
      sym_done = 1'b1;
      sym_rx_bit = rx_b[s];
      @(negedge clk);
      sym_done = 1'b0;
      sym_rx_bit = 1'($urandom);
    end
    check(done == 1'b1, "R8", int'(done), 1);
    check(busy == 1'b0, "R8", int'(busy), 0);
    check(ack_err == rxack, "R8", int'(ack_err), int'(rxack));
    if (wr) begin
      check(parity_err == 1'b0, "R9", int'(parity_err), 0);
      check(rd_data == model_rd, "R9", int'(rd_data), int'(model_rd));
    end else begin
      model_rd = rxd;
      check(rd_data == rxd, "R9", int'(rd_data), int'(rxd));
      check(parity_err == (rxp2 != par_of(rxd)), "R9", int'(parity_err),
            int'(rxp2 != par_of(rxd)));
    end
    @(negedge clk);
    check(done == 1'b0, "R8", int'(done), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1", int'(busy), 0);
    check(done == 0, "R1", int'(done), 0);
    check(sym_valid == 0, "R1", int'(sym_valid), 0);
    check(rd_data == 0, "R1", int'(rd_data), 0);
    check(parity_err == 0 && ack_err == 0, "R1", int'({parity_err, ack_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sym_valid == 0, "R1", int'(sym_valid), 0);

    // directed corners
    run_frame(1'b0, 3'b000, 4'b0000, 8'h00, 8'hA5, 1'b0, 1'b0, 0); // read, good parity
    run_frame(1'b1, 3'b111, 4'b1111, 8'hFF, 8'h00, 1'b0, 1'b0, 0); // write all ones
    run_frame(1'b0, 3'b101, 4'b1010, 8'h00, 8'h00, 1'b0, 1'b1, 0); // write zero byte, NACK
    run_frame(1'b0, 3'b010, 4'b0110, 8'h00, 8'h07, 1'b0, 1'b0, 0); // read, bad parity
    run_frame(1'b1, 3'b001, 4'b0001, 8'h00, 8'h80, 1'b1, 1'b1, 1); // read, NACK, mid-frame start
    run_frame(1'b1, 3'b011, 4'b1000, 8'h01, 8'h00, 1'b0, 1'b0, 1); // write odd byte, mid-frame start

    for (int k = 0; k < 40; k++) begin
      logic [7:0] rxd;
      logic p2;
      rxd = 8'($urandom);
      p2 = ($urandom_range(0, 3) == 0) ? ~par_of(rxd) : par_of(rxd);
      run_frame(1'($urandom), 3'($urandom), 4'($urandom), 8'($urandom), rxd, p2,
                1'($urandom_range(0, 4) == 0), k % 7 == 3);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule